// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block owns the program counter of a 32-bit RISC core whose control transfers carry one architectural delay slot. One instruction is presented per clock, together with the condition flag and the value of the source register rA read for it. The block decodes the control-transfer forms: absolute jumps, PC-relative branches (conditional and linking), register jumps and return-from-exception. It produces the PC of the next instruction, a request to write the link register, and a trap request.

A taken transfer does not redirect at once. The instruction at PC+4, the delay slot, is fetched and completes first. The target is held in a register across that slot and then loaded into the PC. Linking forms write general register 11 with the address after the slot, so that a return continues past it. A transfer that sits inside a delay slot is illegal. It raises a trap request, and the target already held still takes effect.

Top module: `dslot_pc_seq`

## Requirements
- R1: While reset is asserted, pc_o is 0, and slot_o, link_we_o, eret_o and trap_o are all 0.
- R2: Any non-transfer instruction advances the PC by 4. This covers every word whose bits 31:30 are nonzero, sub-opcodes 6 to 15 with bits 31:30 = 0, and register-group words whose form is not listed in R7 or R8.
- R3: When bits 31:30 = 0 and bits 29:26 = 0 (absolute jump), the next instruction is at PC+4 with slot_o = 1, and the one after it is at {instr[25:0], 2'b00}, zero-extended.
- R4: Sub-opcode 4 (branch on flag set) with flag_i = 1 goes through the slot to PC + sign-extended {instr[25:0], 2'b00}. Both positive and negative displacements are covered, and PC is the address of the branch.
- R5: Sub-opcode 3 branches through the slot when flag_i = 0. Sub-opcode 3 with flag_i = 1, and sub-opcode 4 with flag_i = 0, fall through: PC+4 and then PC+8, with slot_o staying 0.
- R6: Sub-opcode 1 (absolute jump-and-link), sub-opcode 2 (PC-relative branch-and-link) and register jump-and-link each assert link_we_o in the transfer's own cycle. In that cycle link_idx_o = 11 and link_data_o = PC+8. Sub-opcode 2 uses the same target as R4.
- R7: Sub-opcode 5 with bits 25:24 = 0 selects a register form. Bits 23:21 = 0 jumps to rA, and bits 23:21 = 1 jumps to rA with a link. The target is the ra_i value presented with the transfer, so a later value of ra_i, or the link write to register 11, does not change it.
- R8: Sub-opcode 5 with bits 25:24 = 0 and bits 23:21 = 2 (return from exception) asserts eret_o in its cycle. It redirects to rA through the slot and does not link.
- R9: A transfer presented while slot_o = 1 asserts trap_o. It does not assert link_we_o or eret_o and opens no new slot, and the PC still moves to the target held from the earlier transfer.
- R10: npc_o always equals the value pc_o takes after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction executing at pc_o |
| flag_i | input | 1 | Condition flag for the conditional branches |
| ra_i | input | 32 | Value of source register rA for this instruction |
| pc_o | output | 32 | PC of the instruction now executing |
| npc_o | output | 32 | PC that is loaded at the next edge |
| slot_o | output | 1 | The current instruction is a delay slot |
| link_we_o | output | 1 | Write request for the link register |
| link_idx_o | output | 5 | Link register index (11) |
| link_data_o | output | 32 | Link value, the current PC plus 8 |
| eret_o | output | 1 | Return-from-exception transfer accepted |
| trap_o | output | 1 | Illegal transfer in a delay slot |

## Verification
The assertions assume that the core presents exactly one instruction per clock, with flag_i and ra_i valid for that same instruction. They also assume the core never stalls: every edge retires the word on instr_i. The stimulus drives a new word, flag and rA at each falling edge and holds them for one full cycle, and the reference model advances one instruction per cycle in the same way. The run includes back-to-back transfers, where the second one falls into a slot, and register-jump targets chosen to differ from the link value. Together these cover the cases where ra_i and the link write could be confused.

// File: rtl/dslot_pc_pkg.sv
package dslot_pc_pkg;

   localparam int unsigned OPW = 32;

   // Sub-opcode values (bits 29:26) when bits 31:30 are zero
   localparam logic [3:0] SUB_JABS  = 4'd0;
   localparam logic [3:0] SUB_JLINK = 4'd1;
   localparam logic [3:0] SUB_BLINK = 4'd2;
   localparam logic [3:0] SUB_BCLR  = 4'd3;
   localparam logic [3:0] SUB_BSET  = 4'd4;
   localparam logic [3:0] SUB_RGRP  = 4'd5;

   // Register group forms (bits 23:21 when bits 25:24 are zero)
   localparam logic [2:0] RF_JMP  = 3'd0;
   localparam logic [2:0] RF_LINK = 3'd1;
   localparam logic [2:0] RF_ERET = 3'd2;

   typedef enum logic [1:0] {
      TK_NONE = 2'd0,
      TK_ABS  = 2'd1,
      TK_REL  = 2'd2,
      TK_REG  = 2'd3
   } tgt_kind_e;

   typedef enum logic [1:0] {
      CD_ALWAYS = 2'd0,
      CD_FSET   = 2'd1,
      CD_FCLR   = 2'd2
   } cond_e;

   typedef struct packed {
      logic      is_xfer;
      tgt_kind_e kind;
      cond_e     cond;
      logic      link;
      logic      eret;
   } xfer_t;

endpackage

// File: rtl/dslot_xfer_dec.sv
module dslot_xfer_dec
   import dslot_pc_pkg::*;
(
   input  logic [31:21] op_i,
   output xfer_t        dec_o
);

   logic [1:0] top;
   logic [3:0] sub;
   logic [1:0] grp;
   logic [2:0] form;

   assign top  = op_i[31:30];
   assign sub  = op_i[29:26];
   assign grp  = op_i[25:24];
   assign form = op_i[23:21];

   always_comb begin
      dec_o = '{is_xfer: 1'b0, kind: TK_NONE, cond: CD_ALWAYS,
                link: 1'b0, eret: 1'b0};
      if (top == 2'b00) begin
         unique case (sub)
            SUB_JABS: begin
               dec_o.is_xfer = 1'b1;
               dec_o.kind    = TK_ABS;
            end
            SUB_JLINK: begin
               dec_o.is_xfer = 1'b1;
               dec_o.kind    = TK_ABS;
               dec_o.link    = 1'b1;
            end
            SUB_BLINK: begin
               dec_o.is_xfer = 1'b1;
               dec_o.kind    = TK_REL;
               dec_o.link    = 1'b1;
            end
            SUB_BCLR: begin
               dec_o.is_xfer = 1'b1;
               dec_o.kind    = TK_REL;
               dec_o.cond    = CD_FCLR;
            end
            SUB_BSET: begin
               dec_o.is_xfer = 1'b1;
               dec_o.kind    = TK_REL;
               dec_o.cond    = CD_FSET;
            end
            SUB_RGRP: begin
               if (grp == 2'b00) begin
                  unique case (form)
                     RF_JMP: begin
                        dec_o.is_xfer = 1'b1;
                        dec_o.kind    = TK_REG;
                     end
                     RF_LINK: begin
                        dec_o.is_xfer = 1'b1;
                        dec_o.kind    = TK_REG;
                        dec_o.link    = 1'b1;
                     end
                     RF_ERET: begin
                        dec_o.is_xfer = 1'b1;
                        dec_o.kind    = TK_REG;
                        dec_o.eret    = 1'b1;
                     end
                     default: ;
                  endcase
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dslot_tgt_calc.sv
module dslot_tgt_calc
   import dslot_pc_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter bit          REG_ALIGN = 1'b0
) (
   input  tgt_kind_e        kind_i,
   input  logic [25:0]      off_i,
   input  logic [XLEN-1:0]  pc_i,
   input  logic [XLEN-1:0]  ra_i,
   output logic [XLEN-1:0]  tgt_o
);

   localparam int unsigned EXT = XLEN - 28;

   logic [XLEN-1:0] abs_tgt;
   logic [XLEN-1:0] rel_tgt;
   logic [XLEN-1:0] reg_tgt;

   assign abs_tgt = {{EXT{1'b0}}, off_i, 2'b00};
   assign rel_tgt = pc_i + {{EXT{off_i[25]}}, off_i, 2'b00};

   generate
      if (REG_ALIGN) begin : g_reg_align
         assign reg_tgt = {ra_i[XLEN-1:2], 2'b00};
      end else begin : g_reg_raw
         assign reg_tgt = ra_i;
      end
   endgenerate

   always_comb begin
      unique case (kind_i)
         TK_ABS:  tgt_o = abs_tgt;
         TK_REL:  tgt_o = rel_tgt;
         TK_REG:  tgt_o = reg_tgt;
         default: tgt_o = pc_i;
      endcase
   end

endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
   import dslot_pc_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned RIDX_W    = 5,
   parameter int unsigned LINK_REG  = 11,
   parameter logic [31:0] RESET_PC  = 32'h0,
   parameter bit          REG_ALIGN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       instr_i,
   input  logic              flag_i,
   input  logic [XLEN-1:0]   ra_i,
   output logic [XLEN-1:0]   pc_o,
   output logic [XLEN-1:0]   npc_o,
   output logic              slot_o,
   output logic              link_we_o,
   output logic [RIDX_W-1:0] link_idx_o,
   output logic [XLEN-1:0]   link_data_o,
   output logic              eret_o,
   output logic              trap_o
);

   localparam logic [XLEN-1:0] STEP   = XLEN'(4);
   localparam logic [XLEN-1:0] LSTEP  = XLEN'(8);
   localparam logic [XLEN-1:0] PC_RST = XLEN'(RESET_PC);

   initial begin
      assert_xlen_ok_R2: assert (XLEN >= 32);
      assert_ridx_ok_R6: assert (LINK_REG < (1 << RIDX_W));
   end

   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] tgt_q;
   logic            slot_q;

   xfer_t           dec;
   logic [XLEN-1:0] tgt_new;
   logic            cond_ok;
   logic            take;

   dslot_xfer_dec u_dec (
      .op_i  (instr_i[31:21]),
      .dec_o (dec)
   );

   dslot_tgt_calc #(
      .XLEN      (XLEN),
      .REG_ALIGN (REG_ALIGN)
   ) u_tgt (
      .kind_i (dec.kind),
      .off_i  (instr_i[25:0]),
      .pc_i   (pc_q),
      .ra_i   (ra_i),
      .tgt_o  (tgt_new)
   );

   always_comb begin
      unique case (dec.cond)
         CD_FSET: cond_ok = flag_i;
         CD_FCLR: cond_ok = !flag_i;
         default: cond_ok = 1'b1;
      endcase
   end

   assign take        = !slot_q && dec.is_xfer && cond_ok;
   assign npc_o       = slot_q ? tgt_q : (pc_q + STEP);
   assign pc_o        = pc_q;
   assign slot_o      = slot_q;
   assign link_we_o   = !slot_q && dec.is_xfer && dec.link;
   assign link_idx_o  = RIDX_W'(LINK_REG);
   assign link_data_o = pc_q + LSTEP;
   assign eret_o      = !slot_q && dec.is_xfer && dec.eret;
   assign trap_o      = slot_q && dec.is_xfer;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= PC_RST;
         slot_q <= 1'b0;
         tgt_q  <= '0;
      end else begin
         pc_q   <= npc_o;
         slot_q <= take;
         if (take) tgt_q <= tgt_new;
      end
   end

   assert_one_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q |=> !slot_q);

   assert_slot_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q |=> (pc_q == $past(tgt_q)));

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_q && !take) |=> (pc_q == $past(pc_q) + STEP));

   assert_link_opens_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |=> slot_q);

   assert_trap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (!link_we_o && !eret_o));

   assert_eret_opens_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eret_o |=> slot_q);

endmodule

// File: tb/tb_dslot_pc_seq.sv
module tb_dslot_pc_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr_i;
   logic        flag_i;
   logic [31:0] ra_i;
   logic [31:0] pc_o, npc_o, link_data_o;
   logic        slot_o, link_we_o, eret_o, trap_o;
   logic [4:0]  link_idx_o;

   localparam logic [31:0] NOP = 32'hC000_0000;

   always #5 clk = ~clk;

   dslot_pc_seq dut (
      .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .flag_i(flag_i), .ra_i(ra_i),
      .pc_o(pc_o), .npc_o(npc_o), .slot_o(slot_o), .link_we_o(link_we_o),
      .link_idx_o(link_idx_o), .link_data_o(link_data_o), .eret_o(eret_o),
      .trap_o(trap_o)
   );

   typedef struct {
      logic [31:0] pc;
      logic [31:0] npc;
      logic [31:0] ld;
      logic        lw;
      logic        er;
      logic        tr;
      logic        sl;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   logic [31:0] m_pc = 32'h0;
   logic [31:0] m_tgt = 32'h0;
   logic        m_slot = 1'b0;
   logic [31:0] prev_npc = 32'h0;
   bit          have_prev = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: present one instruction, model its effect, push expectation
   task automatic issue(input logic [31:0] ins, input logic fl, input logic [31:0] ra,
                        input string tag);
      exp_t e;
      logic [1:0]  top;
      logic [3:0]  sub;
      logic        xf, lk, er, tk;
      logic [31:0] tg;
      logic [31:0] roff;
      top  = ins[31:30];
      sub  = ins[29:26];
      roff = {{4{ins[25]}}, ins[25:0], 2'b00};
      xf = 0; lk = 0; er = 0; tk = 0; tg = 32'h0;
      if (top == 2'b00) begin
         case (sub)
            4'd0: begin xf = 1; tk = 1; tg = {4'h0, ins[25:0], 2'b00}; end
            4'd1: begin xf = 1; tk = 1; lk = 1; tg = {4'h0, ins[25:0], 2'b00}; end
            4'd2: begin xf = 1; tk = 1; lk = 1; tg = m_pc + roff; end
            4'd3: begin xf = 1; tk = !fl; tg = m_pc + roff; end
            4'd4: begin xf = 1; tk = fl; tg = m_pc + roff; end
            4'd5: if (ins[25:24] == 2'b00 && ins[23:21] <= 3'd2) begin
               xf = 1; tk = 1; tg = ra;
               lk = (ins[23:21] == 3'd1);
               er = (ins[23:21] == 3'd2);
            end
            default: ;
         endcase
      end
      instr_i = ins; flag_i = fl; ra_i = ra;
      e.pc  = m_pc;
      e.sl  = m_slot;
      e.tr  = m_slot && xf;
      e.lw  = !m_slot && lk;
      e.er  = !m_slot && er;
      e.ld  = m_pc + 32'd8;
      e.npc = m_slot ? m_tgt : m_pc + 32'd4;
      e.tag = tag;
      q.push_back(e);
      if (!m_slot && tk) begin
         m_slot = 1'b1;
         m_tgt  = tg;
      end else begin
         m_slot = 1'b0;
      end
      m_pc = e.npc;
      @(negedge clk);
   endtask

   // Monitor: sample just before the rising edge and compare
   initial begin
      forever begin
         @(negedge clk);
         #4;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " pc"},    pc_o,  e.pc);
            chk({e.tag, " npc"},   npc_o, e.npc);
            chk({e.tag, " slot"},  {31'h0, slot_o},    {31'h0, e.sl});
            chk({e.tag, " link"},  {31'h0, link_we_o}, {31'h0, e.lw});
            chk({e.tag, " eret"},  {31'h0, eret_o},    {31'h0, e.er});
            chk({e.tag, " trap"},  {31'h0, trap_o},    {31'h0, e.tr});
            if (e.lw) begin
               chk({e.tag, " link data R6"}, link_data_o, e.ld);
               chk({e.tag, " link idx R6"},  {27'h0, link_idx_o}, 32'd11);
            end
            // R10: npc seen in the previous cycle is the pc now
            if (have_prev) chk("R10 npc becomes pc", pc_o, prev_npc);
            prev_npc  = npc_o;
            have_prev = 1'b1;
         end else begin
            have_prev = 1'b0;
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      instr_i = NOP; flag_i = 0; ra_i = 32'h0;
      repeat (3) @(negedge clk);
      #4;
      chk("R1 reset pc", pc_o, 32'h0);
      chk("R1 reset slot", {31'h0, slot_o}, 32'h0);
      chk("R1 reset link", {31'h0, link_we_o}, 32'h0);
      chk("R1 reset eret/trap", {30'h0, eret_o, trap_o}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      issue(NOP, 0, 0, "R2 nop");
      issue(32'h4000_0000, 0, 0, "R2 top01 sub0");
      issue(32'h1C00_0000, 0, 0, "R2 sub7");
      // R3 absolute jump to 0x100
      issue({2'b00, 4'd0, 26'h40}, 0, 0, "R3 jump");
      issue(NOP, 0, 0, "R3 slot");
      issue(NOP, 0, 0, "R3 landed");
      // R6 jump-and-link to 0x200
      issue({2'b00, 4'd1, 26'h80}, 0, 32'h1234, "R6 jal");
      issue(NOP, 1, 0, "R6 slot");
      // R4 branch on flag set, negative displacement -4 words
      issue({2'b00, 4'd4, 26'h3FF_FFFC}, 1, 0, "R4 bf neg");
      issue(NOP, 0, 0, "R4 slot");
      issue({2'b00, 4'd4, 26'h10}, 1, 0, "R4 bf pos");
      issue(NOP, 0, 0, "R4 slot2");
      // R5 not-taken cases and branch on flag clear
      issue({2'b00, 4'd4, 26'h10}, 0, 0, "R5 bf not taken");
      issue({2'b00, 4'd3, 26'h10}, 1, 0, "R5 bnf not taken");
      issue({2'b00, 4'd3, 26'h8}, 0, 0, "R5 bnf taken");
      issue(NOP, 0, 0, "R5 slot");
      // R6 branch-and-link pc relative
      issue({2'b00, 4'd2, 26'h20}, 0, 0, "R6 bal");
      issue(NOP, 0, 0, "R6 bal slot");
      // R7 register jumps; rA changes in the slot
      issue({2'b00, 4'd5, 2'b00, 3'd0, 21'h0}, 0, 32'h400, "R7 jr");
      issue(NOP, 0, 32'hDEAD_0000, "R7 jr slot");
      issue({2'b00, 4'd5, 2'b00, 3'd1, 21'h0}, 0, 32'h500, "R7 jalr");
      issue(NOP, 0, 32'h0000_0BAD, "R7 jalr slot");
      // R8 return from exception
      issue({2'b00, 4'd5, 2'b00, 3'd2, 21'h0}, 0, 32'h600, "R8 eret");
      issue(NOP, 0, 0, "R8 slot");
      // R2 register-group words that are not transfers
      issue({2'b00, 4'd5, 2'b01, 3'd0, 21'h0}, 0, 32'h900, "R2 grp nop");
      issue({2'b00, 4'd5, 2'b00, 3'd3, 21'h0}, 0, 32'h900, "R2 grp form3");
      // R9 transfer in a slot
      issue({2'b00, 4'd0, 26'h1C0}, 0, 0, "R9 jump");
      issue({2'b00, 4'd1, 26'h200}, 0, 0, "R9 jal in slot");
      issue({2'b00, 4'd5, 2'b00, 3'd2, 21'h0}, 0, 32'hA00, "R9 eret after slot");
      issue({2'b00, 4'd4, 26'h4}, 1, 0, "R9 bf in slot");
      issue(NOP, 0, 0, "R9 tail");
      issue(NOP, 0, 0, "R9 tail2");

      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule